// File: doc/BRIEF.md
# Power-Fail Protected Byte-Wide SRAM Controller

This block is the synchronous control logic placed in front of a battery-backed static RAM array. It turns three active-low strobes (chip enable, write enable, output enable) into read, write and output-drive actions on an internal byte array. All timing is counted in clock cycles. The supply inputs arrive as two digital comparator flags that are already synchronised.

A write lasts as long as chip enable and write enable are both low. The strobes may fall and rise in any order. The byte is committed when the window closes. The data stored is the last data seen while the window was open, and the address used is the one captured when the window opened.

A four-state supply machine watches the two flags. States are normal, deselected, battery and recovering. When the supply drops, the machine removes all access, releases the data bus and requests battery supply. When the supply returns, access stays locked out for a programmable number of cycles.

Top module: `pfsram_ctrl`

## Requirements
- R1: In the normal state, a sample with `ce_n`=0, `oe_n`=0 and `we_n`=1 gives `rdata_oe`=1 and `rdata` equal to the stored byte at `addr`. Both appear one clock after the sample. Otherwise `rdata_oe`=0 and `rdata`=0.
- R2: The write window is open while `ce_n` and `we_n` are both low. The byte is written when the window closes, whichever strobe rises first. It goes to the address present at the opening sample, with the `wdata` of the last open sample. The order in which the strobes fall has no effect.
- R3: If `addr` differs from the captured address on a sample where the window stays open, `addr_err` is 1 for exactly one clock after that sample.
- R4: Suppose outputs are driving and `we_n` goes low. Then `rdata_oe` stays 1 for WLQZ_CYC more clocks and then drops to 0.
- R5: One clock after `vcc_trip_ok` is sampled low, the block is deselected. In that state `rdata_oe` is 0, strobes are ignored and no byte can be written.
- R6: Loss of `vcc_trip_ok` during an open write window aborts the write. No byte changes, including the addressed one.
- R7: `batt_sel` is 1 one clock after `vcc_swo_ok` is sampled low. It is 0 one clock after `vcc_swo_ok` is sampled high.
- R8: Both flags may be sampled high while the block is deselected or on battery (or while leaving reset). In that case a held read strobe first produces `rdata_oe`=1 exactly REC_CYC+2 clocks later.
- R9: A bus cycle is idle when `ce_n`=1, or when `we_n`=1 and `oe_n`=1 together. A new cycle is accepted only after GAP_CYC consecutive idle samples. A strobe that comes too early is ignored until the bus has been idle for GAP_CYC samples again.
- R10: While `rst_n` is low, `rdata_oe`, `batt_sel` and `addr_err` are 0 and the block is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, zero when not driving |
| rdata_oe | output | 1 | Data bus drive enable |
| vcc_trip_ok | input | 1 | Supply above upper power-fail threshold |
| vcc_swo_ok | input | 1 | Supply above battery switchover level |
| batt_sel | output | 1 | Battery supply selected |
| addr_err | output | 1 | Address moved inside a write window |

## Verification
The bench opens write windows with every combination of which strobe falls first and which rises first. A controller that sampled the address or data at the wrong edge would store a byte that a later read does not return.

It drops the power-fail flag in the middle of a window and checks two things: the addressed byte keeps its old value, and a write attempted while deselected never lands. A design that committed on the forced close would fail here.

It counts the exact clock at which the drive enable turns on after the recovery lockout, and the clock at which it turns off after write enable falls. An off-by-one counter shows up directly in those counts.

It issues a read too soon after a cycle ends and expects it to be ignored. It then expects a properly spaced read to succeed.

// File: rtl/pfsram_pkg.sv
package pfsram_pkg;
   typedef enum logic [1:0] {
      PS_NORMAL = 2'd0,
      PS_DESEL  = 2'd1,
      PS_BATT   = 2'd2,
      PS_RECOV  = 2'd3
   } pwr_state_t;
endpackage

// File: rtl/pfsram_supply.sv
module pfsram_supply
   import pfsram_pkg::*;
#(
   parameter int REC_CYC = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       trip_ok,
   input  logic       swo_ok,
   output pwr_state_t state,
   output logic       batt_sel
);
   localparam int CW = $clog2(REC_CYC + 1);
   localparam logic [CW-1:0] CNT_LAST = CW'(REC_CYC - 1);

   pwr_state_t nxt;
   logic [CW-1:0] cnt_q;

   always_comb begin
      if (!swo_ok)       nxt = PS_BATT;
      else if (!trip_ok) nxt = PS_DESEL;
      else begin
         case (state)
            PS_DESEL, PS_BATT: nxt = PS_RECOV;
            PS_RECOV:          nxt = (cnt_q == CNT_LAST) ? PS_NORMAL : PS_RECOV;
            default:           nxt = PS_NORMAL;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= PS_DESEL;
         cnt_q <= '0;
      end else begin
         state <= nxt;
         if (state != PS_RECOV) cnt_q <= '0;
         else                   cnt_q <= cnt_q + 1'b1;
      end
   end

   assign batt_sel = (state == PS_BATT);

   assert_batt_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !swo_ok |=> batt_sel);
   assert_batt_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      swo_ok |=> !batt_sel);
   assert_lockout_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_RECOV && cnt_q != CNT_LAST) |=> state != PS_NORMAL);
   assert_normal_via_recov_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_DESEL || state == PS_BATT) |=> state != PS_NORMAL);
endmodule

// File: rtl/pfsram_strobe.sv
module pfsram_strobe #(
   parameter int ADDR_W   = 10,
   parameter int DATA_W   = 8,
   parameter int GAP_CYC  = 2,
   parameter int WLQZ_CYC = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              access_en,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              rd_drive,
   output logic              addr_err
);
   localparam int GW = $clog2(GAP_CYC + 1);
   localparam logic [GW-1:0] GAP_MAX = GW'(GAP_CYC);

   logic [GW-1:0] gap_q;
   logic in_cyc_q, win_q, win_now, idle, go, armed, we_hold;

   assign idle    = ce_n | (we_n & oe_n);
   assign armed   = (gap_q == GAP_MAX);
   assign go      = access_en & ~idle & (in_cyc_q | armed);
   assign win_now = go & ~we_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_q    <= GAP_MAX;
         in_cyc_q <= 1'b0;
         win_q    <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
         addr_err <= 1'b0;
      end else begin
         in_cyc_q <= go;
         win_q    <= win_now;
         if (!access_en)  gap_q <= GAP_MAX;
         else if (!idle)  gap_q <= '0;
         else if (!armed) gap_q <= gap_q + 1'b1;
         if (win_now && !win_q) wr_addr <= addr;
         if (win_now)           wr_data <= wdata;
         addr_err <= win_q & win_now & (addr != wr_addr);
      end
   end

   assign wr_en = win_q & ~win_now & access_en;

   generate
      if (WLQZ_CYC == 0) begin : g_wlqz_now
         assign we_hold = 1'b0;
      end else begin : g_wlqz_cnt
         localparam int WW = $clog2(WLQZ_CYC + 1);
         localparam logic [WW-1:0] WMAX = WW'(WLQZ_CYC);
         logic [WW-1:0] wl_q;
         always_ff @(posedge clk) begin
            if (!rst_n || we_n)  wl_q <= '0;
            else if (wl_q != WMAX) wl_q <= wl_q + 1'b1;
         end
         assign we_hold = (wl_q < WMAX);
      end
   endgenerate

   assign rd_drive = go & ~oe_n & (we_n | we_hold);

   assert_err_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      addr_err |-> $past(!we_n && !ce_n));
   assert_commit_after_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(!we_n && !ce_n));
endmodule

// File: rtl/pfsram_array.sv
module pfsram_array #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] q
);
   localparam int DEPTH = 1 << ADDR_W;
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
      q <= mem[rd_addr];
   end
endmodule

// File: rtl/pfsram_ctrl.sv
module pfsram_ctrl
   import pfsram_pkg::*;
#(
   parameter int ADDR_W   = 10,
   parameter int DATA_W   = 8,
   parameter int REC_CYC  = 16,
   parameter int GAP_CYC  = 2,
   parameter int WLQZ_CYC = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_oe,
   input  logic              vcc_trip_ok,
   input  logic              vcc_swo_ok,
   output logic              batt_sel,
   output logic              addr_err
);
   generate
      if (ADDR_W < 1 || ADDR_W > 15) begin : g_bad_addr_w
         $error("pfsram_ctrl: ADDR_W out of range 1..15");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("pfsram_ctrl: DATA_W must be positive");
      end
      if (REC_CYC < 1 || GAP_CYC < 1 || WLQZ_CYC < 0) begin : g_bad_cyc
         $error("pfsram_ctrl: cycle counts out of range");
      end
   endgenerate

   pwr_state_t        pstate;
   logic              access_en, wr_en, rd_drive, oe_q;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data, q;

   pfsram_supply #(.REC_CYC(REC_CYC)) u_supply (
      .clk(clk), .rst_n(rst_n), .trip_ok(vcc_trip_ok), .swo_ok(vcc_swo_ok),
      .state(pstate), .batt_sel(batt_sel)
   );

   assign access_en = (pstate == PS_NORMAL);

   pfsram_strobe #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GAP_CYC(GAP_CYC), .WLQZ_CYC(WLQZ_CYC)
   ) u_strobe (
      .clk(clk), .rst_n(rst_n), .access_en(access_en),
      .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .wdata(wdata),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_drive(rd_drive), .addr_err(addr_err)
   );

   pfsram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
      .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(addr), .q(q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) oe_q <= 1'b0;
      else        oe_q <= rd_drive;
   end

   assign rdata_oe = oe_q;
   assign rdata    = oe_q ? q : '0;

   assert_hiz_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pstate != PS_NORMAL) |=> !rdata_oe);
   assert_no_write_after_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(vcc_trip_ok && vcc_swo_ok));
   assert_drive_needs_strobes_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_oe |-> $past(!ce_n && !oe_n));
endmodule

// File: tb/pfsram_ctrl_tb.sv
module pfsram_ctrl_tb;
   localparam int AW = 8, DW = 8, REC = 12, GAP = 3, WLQZ = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic rdata_oe, batt_sel, addr_err;
   logic trip_ok = 1'b1, swo_ok = 1'b1;

   logic [DW-1:0] ref_mem [1 << AW];
   int checks = 0, fails = 0;

   always #5 clk = ~clk;

   pfsram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .REC_CYC(REC), .GAP_CYC(GAP), .WLQZ_CYC(WLQZ)) u_dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
      .vcc_trip_ok(trip_ok), .vcc_swo_ok(swo_ok), .batt_sel(batt_sel), .addr_err(addr_err)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int exp_recov_wait(input int rec);
      return rec + 2;
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_write(input int a, input logic [DW-1:0] d, input bit we_first, input bit close_we);
      addr = AW'(a); wdata = d;
      if (we_first) we_n = 1'b0; else ce_n = 1'b0;
      tick(1);
      ce_n = 1'b0; we_n = 1'b0;
      tick(2);
      if (close_we) we_n = 1'b1; else ce_n = 1'b1;
      tick(1);
      ce_n = 1'b1; we_n = 1'b1;
      ref_mem[a] = d;
      tick(GAP);
   endtask

   task automatic do_read(input int a, input string req);
      addr = AW'(a); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
      tick(1);
      check(req, int'(rdata_oe), 1);
      check(req, int'(rdata), int'(ref_mem[a]));
      ce_n = 1'b1; oe_n = 1'b1;
      tick(GAP);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int n;
      void'($urandom(32'h5eed_1234));
      // R10: reset state
      tick(3);
      check("R10 oe", int'(rdata_oe), 0);
      check("R10 batt", int'(batt_sel), 0);
      check("R10 err", int'(addr_err), 0);
      // R8: lockout leaving reset, read strobe held
      addr = '0; ce_n = 1'b0; oe_n = 1'b0; rst_n = 1'b1;
      n = 0;
      while (!rdata_oe && n < 100) begin tick(1); n++; end
      check("R8 reset lockout", n, exp_recov_wait(REC));
      ce_n = 1'b1; oe_n = 1'b1; tick(GAP);

      // fill array, all four strobe orders (R2)
      for (int a = 0; a < (1 << AW); a++)
         do_write(a, DW'(a * 7 + 3), a[0], a[1]);
      for (int a = 0; a < 8; a++) do_read(a, "R2 order");

      // R1: oe high with ce low gives no drive
      addr = 8'd5; ce_n = 1'b0; oe_n = 1'b1; tick(1);
      check("R1 no oe", int'(rdata_oe), 0);
      check("R1 zero data", int'(rdata), 0);
      ce_n = 1'b1; tick(GAP);

      // R3: address moves inside window; commit to opening address
      addr = 8'd20; wdata = 8'hA5; ce_n = 1'b0; we_n = 1'b0; tick(1);
      addr = 8'd21; tick(1);
      check("R3 err set", int'(addr_err), 1);
      addr = 8'd20; tick(1);
      check("R3 err pulse", int'(addr_err), 0);
      we_n = 1'b1; tick(1); ce_n = 1'b1; tick(GAP);
      ref_mem[20] = 8'hA5;
      do_read(20, "R3 commit addr");
      do_read(21, "R3 neighbour");

      // R4: drive-off delay after we falls
      addr = 8'd30; ce_n = 1'b0; oe_n = 1'b0; tick(1);
      check("R4 driving", int'(rdata_oe), 1);
      wdata = 8'h3C; we_n = 1'b0; tick(WLQZ);
      check("R4 still on", int'(rdata_oe), 1);
      tick(1);
      check("R4 off", int'(rdata_oe), 0);
      we_n = 1'b1; tick(1); ce_n = 1'b1; oe_n = 1'b1; tick(GAP);
      ref_mem[30] = 8'h3C;
      do_read(30, "R4 write landed");

      // R9: read too soon after a cycle ends is ignored
      addr = 8'd40; wdata = 8'h77; ce_n = 1'b0; we_n = 1'b0; tick(2);
      we_n = 1'b1; ce_n = 1'b1; tick(1);
      ref_mem[40] = 8'h77;
      ce_n = 1'b0; oe_n = 1'b0; tick(1);
      check("R9 early ignored", int'(rdata_oe), 0);
      tick(1);
      check("R9 stays ignored", int'(rdata_oe), 0);
      ce_n = 1'b1; oe_n = 1'b1; tick(GAP);
      do_read(40, "R9 spaced read");

      // R6/R5: power loss mid-write
      ref_mem[50] = 8'h11;
      do_write(50, 8'h11, 1'b0, 1'b1);
      addr = 8'd50; wdata = 8'hEE; ce_n = 1'b0; we_n = 1'b0; tick(1);
      trip_ok = 1'b0; tick(1);
      we_n = 1'b1; ce_n = 1'b1; tick(1);
      check("R7 batt low on deselect", int'(batt_sel), 0);
      // R5: deselected read and write ignored
      addr = 8'd51; ce_n = 1'b0; oe_n = 1'b0; tick(2);
      check("R5 read blocked", int'(rdata_oe), 0);
      oe_n = 1'b1; we_n = 1'b0; wdata = 8'h99; tick(3);
      we_n = 1'b1; ce_n = 1'b1; tick(1);
      // R7: battery select
      swo_ok = 1'b0; tick(1);
      check("R7 batt on", int'(batt_sel), 1);
      tick(2);
      swo_ok = 1'b1; tick(1);
      check("R7 batt off", int'(batt_sel), 0);
      // R8: recovery lockout from deselect
      addr = 8'd50; ce_n = 1'b0; oe_n = 1'b0; trip_ok = 1'b1;
      n = 0;
      while (!rdata_oe && n < 100) begin tick(1); n++; end
      check("R8 recovery lockout", n, exp_recov_wait(REC));
      check("R6 addressed byte kept", int'(rdata), int'(ref_mem[50]));
      ce_n = 1'b1; oe_n = 1'b1; tick(GAP);
      do_read(51, "R5 deselected write blocked");
      do_read(49, "R6 neighbour kept");

      // random mix (R1, R2)
      for (int i = 0; i < 300; i++) begin
         int a;
         a = int'($urandom_range((1 << AW) - 1, 0));
         if ($urandom_range(1, 0) == 1)
            do_write(a, DW'($urandom), 1'($urandom), 1'($urandom));
         else
            do_read(a, "R1 random read");
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule